// File: doc/BRIEF.md
# Multi-core power-state resolver

This block sits between the per-thread power requests of a multi-core cluster and the hardware that applies them. Each core runs two hardware threads. Every thread presents a requested performance-state index (lower index means faster and hungrier) and a requested idle state. The block folds these into one idle state per core, one performance state for the whole package, a package-wide enable for the low-voltage halt state, and a flag saying the conditions for turbo operation are met.

The package has a single frequency and voltage point. It is set by the fastest request among threads that are actually running. A core sleeps no deeper than its shallowest thread. The low-voltage halt state and turbo both depend on the state of the whole cluster. Results are registered, so every output reflects the inputs sampled one clock earlier.

Top module: `pwr_state_resolver`

## Requirements
- R1: While rst_ni is low, every core_idle_o field reads 0 (running), pkg_pstate_o reads P_MAX, and c1e_en_o and turbo_ok_o read 0.
- R2: Idle codes are 0 running, 1 halt, 2 halt with lowest voltage, 3 cache-flushed sleep, 6 power-gated sleep. Depth follows the numeric code. Codes 4, 5 and 7 are treated as 1. Thread t of core c uses field index 2*c+t of each input. Core c shows the shallower of its two threads in core_idle_o[3*c +: 3].
- R3: c1e_en_o is 1 only when the merged state of every core is 2. When it is 0, any core whose merged state is 2 shows 1 instead.
- R4: pkg_pstate_o is the minimum performance index over all threads whose idle code is 0. Requests from threads in any other code, including 4, 5 and 7, are ignored.
- R5: When no thread has idle code 0, pkg_pstate_o is P_MAX.
- R6: A performance request above P_MAX counts as P_MAX.
- R7: turbo_ok_o is 1 exactly when NUM_CORES-1 cores have a merged state of 3 or 6 and the remaining core is running (0).
- R8: All outputs are registered. A change on the inputs appears at the outputs after the next rising clock edge and not before.
- R9: Each core's idle state is resolved independently, so different cores may show different idle states in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| thr_pstate_i | input | 2*NUM_CORES*PW | Per-thread performance request, field 2*c+t |
| thr_idle_i | input | 2*NUM_CORES*3 | Per-thread idle request, field 2*c+t |
| core_idle_o | output | NUM_CORES*3 | Applied idle state per core |
| pkg_pstate_o | output | PW | Package performance index |
| c1e_en_o | output | 1 | Whole package in low-voltage halt |
| turbo_ok_o | output | 1 | Turbo conditions met |

## Verification
A wrong merge or demotion inside the block shows up as a wrong core_idle_o field one edge after the stimulus. It also disturbs the package flags in the same cycle: c1e_en_o would then disagree with the core fields, or turbo_ok_o would be set without exactly one running core. A thread wrongly counted as running, or a request left unclamped, surfaces at once in pkg_pstate_o. All-idle vectors expose the P_MAX fallback. Because nothing is accumulated across cycles, every fault is visible at the first sample after the edge that loads the faulty vector.

// File: rtl/pwr_res_pkg.sv
package pwr_res_pkg;
  localparam int IDLE_W = 3;

  typedef enum logic [IDLE_W-1:0] {
    IDLE_RUN  = 3'd0,
    IDLE_HALT = 3'd1,
    IDLE_HLV  = 3'd2,
    IDLE_SLP  = 3'd3,
    IDLE_OFF  = 3'd6
  } idle_e;

  // undefined codes fall back to plain halt
  function automatic logic [IDLE_W-1:0] norm_idle(input logic [IDLE_W-1:0] code);
    case (code)
      3'd0, 3'd1, 3'd2, 3'd3, 3'd6: norm_idle = code;
      default:                      norm_idle = IDLE_HALT;
    endcase
  endfunction
endpackage

// File: rtl/pwr_core_merge.sv
module pwr_core_merge
  import pwr_res_pkg::*;
#(
  parameter int P_MAX = 11,
  parameter int PW    = $clog2(P_MAX + 1)
) (
  input  logic [IDLE_W-1:0] idle_a_i,
  input  logic [IDLE_W-1:0] idle_b_i,
  input  logic [PW-1:0]     pst_a_i,
  input  logic [PW-1:0]     pst_b_i,
  output logic [IDLE_W-1:0] idle_o,
  output logic [PW-1:0]     pst_o,
  output logic              run_o,
  output logic              deep_o
);
  localparam logic [PW-1:0] PMAX_V = PW'(P_MAX);

  logic [IDLE_W-1:0] na, nb;
  logic [PW-1:0]     ca, cb, va, vb;

  always_comb begin
    na = norm_idle(idle_a_i);
    nb = norm_idle(idle_b_i);
    idle_o = (na < nb) ? na : nb;
    ca = (pst_a_i > PMAX_V) ? PMAX_V : pst_a_i;
    cb = (pst_b_i > PMAX_V) ? PMAX_V : pst_b_i;
    // sleeping threads do not vote
    va = (na == IDLE_RUN) ? ca : PMAX_V;
    vb = (nb == IDLE_RUN) ? cb : PMAX_V;
    pst_o  = (va < vb) ? va : vb;
    run_o  = (idle_o == IDLE_RUN);
    deep_o = (idle_o == IDLE_SLP) || (idle_o == IDLE_OFF);
  end
endmodule

// File: rtl/pwr_pkg_reduce.sv
module pwr_pkg_reduce
  import pwr_res_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int P_MAX     = 11,
  parameter int PW        = $clog2(P_MAX + 1)
) (
  input  logic [NUM_CORES*IDLE_W-1:0] core_idle_i,
  input  logic [NUM_CORES*PW-1:0]     core_pst_i,
  input  logic [NUM_CORES-1:0]        core_run_i,
  input  logic [NUM_CORES-1:0]        core_deep_i,
  output logic [PW-1:0]               pkg_pst_o,
  output logic                        all_hlv_o,
  output logic                        turbo_o
);
  localparam int CW = $clog2(NUM_CORES + 1);
  localparam logic [PW-1:0] PMAX_V = PW'(P_MAX);

  logic [CW-1:0] n_deep, n_run;

  always_comb begin
    pkg_pst_o = PMAX_V;
    all_hlv_o = 1'b1;
    n_deep    = '0;
    n_run     = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (core_pst_i[c*PW +: PW] < pkg_pst_o) pkg_pst_o = core_pst_i[c*PW +: PW];
      if (core_idle_i[c*IDLE_W +: IDLE_W] != IDLE_HLV) all_hlv_o = 1'b0;
      n_deep = n_deep + CW'(core_deep_i[c]);
      n_run  = n_run + CW'(core_run_i[c]);
    end
    turbo_o = (n_deep == CW'(NUM_CORES - 1)) && (n_run == CW'(1));
  end
endmodule

// File: rtl/pwr_state_resolver.sv
module pwr_state_resolver
  import pwr_res_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int P_MAX     = 11,
  parameter int PW        = $clog2(P_MAX + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [2*NUM_CORES*PW-1:0]     thr_pstate_i,
  input  logic [2*NUM_CORES*IDLE_W-1:0] thr_idle_i,
  output logic [NUM_CORES*IDLE_W-1:0]   core_idle_o,
  output logic [PW-1:0]                 pkg_pstate_o,
  output logic                          c1e_en_o,
  output logic                          turbo_ok_o
);
  logic [NUM_CORES*IDLE_W-1:0] m_idle, d_idle;
  logic [NUM_CORES*PW-1:0]     m_pst;
  logic [NUM_CORES-1:0]        m_run, m_deep;
  logic [PW-1:0]               n_pst;
  logic                        n_hlv, n_turbo;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    pwr_core_merge #(.P_MAX(P_MAX), .PW(PW)) u_merge (
      .idle_a_i (thr_idle_i[(2*c)*IDLE_W +: IDLE_W]),
      .idle_b_i (thr_idle_i[(2*c+1)*IDLE_W +: IDLE_W]),
      .pst_a_i  (thr_pstate_i[(2*c)*PW +: PW]),
      .pst_b_i  (thr_pstate_i[(2*c+1)*PW +: PW]),
      .idle_o   (m_idle[c*IDLE_W +: IDLE_W]),
      .pst_o    (m_pst[c*PW +: PW]),
      .run_o    (m_run[c]),
      .deep_o   (m_deep[c])
    );
    // low-voltage halt only survives when the whole package agrees
    assign d_idle[c*IDLE_W +: IDLE_W] =
      (!n_hlv && m_idle[c*IDLE_W +: IDLE_W] == IDLE_HLV) ? IDLE_HALT
                                                         : m_idle[c*IDLE_W +: IDLE_W];
  end

  pwr_pkg_reduce #(.NUM_CORES(NUM_CORES), .P_MAX(P_MAX), .PW(PW)) u_reduce (
    .core_idle_i (m_idle),
    .core_pst_i  (m_pst),
    .core_run_i  (m_run),
    .core_deep_i (m_deep),
    .pkg_pst_o   (n_pst),
    .all_hlv_o   (n_hlv),
    .turbo_o     (n_turbo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_idle_o  <= '0;
      pkg_pstate_o <= PW'(P_MAX);
      c1e_en_o     <= 1'b0;
      turbo_ok_o   <= 1'b0;
    end else begin
      core_idle_o  <= d_idle;
      pkg_pstate_o <= n_pst;
      c1e_en_o     <= n_hlv;
      turbo_ok_o   <= n_turbo;
    end
  end
endmodule

// File: rtl/pwr_state_resolver_chk.sv
module pwr_state_resolver_chk #(
  parameter int NUM_CORES = 4,
  parameter int P_MAX     = 11,
  parameter int PW        = $clog2(P_MAX + 1)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [2*NUM_CORES*PW-1:0] thr_pstate_i,
  input logic [2*NUM_CORES*3-1:0]  thr_idle_i,
  input logic [NUM_CORES*3-1:0]    core_idle_o,
  input logic [PW-1:0]             pkg_pstate_o,
  input logic                      c1e_en_o,
  input logic                      turbo_ok_o
);
  localparam int CW = $clog2(NUM_CORES + 1);

  logic [1:0]    age;
  logic [CW-1:0] n_run, n_deep, n_hlv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always_comb begin
    n_run = '0; n_deep = '0; n_hlv = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      n_run  = n_run  + CW'(core_idle_o[c*3 +: 3] == 3'd0);
      n_deep = n_deep + CW'(core_idle_o[c*3 +: 3] == 3'd3 || core_idle_o[c*3 +: 3] == 3'd6);
      n_hlv  = n_hlv  + CW'(core_idle_o[c*3 +: 3] == 3'd2);
    end
  end

  a_r3_hlv_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c1e_en_o |-> (n_hlv == CW'(NUM_CORES)));
  a_r3_hlv_demoted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c1e_en_o |-> (n_hlv == '0));
  a_r5_all_idle_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_run == '0) |-> (pkg_pstate_o == PW'(P_MAX)));
  a_r6_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkg_pstate_o <= PW'(P_MAX));
  a_r7_turbo_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turbo_ok_o |-> (n_run == CW'(1) && n_deep == CW'(NUM_CORES - 1)));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3 && $past(thr_idle_i) == $past(thr_idle_i, 2)
                 && $past(thr_pstate_i) == $past(thr_pstate_i, 2))
    |-> ($stable(core_idle_o) && $stable(pkg_pstate_o)
         && $stable(c1e_en_o) && $stable(turbo_ok_o)));
endmodule

bind pwr_state_resolver pwr_state_resolver_chk #(
  .NUM_CORES(NUM_CORES), .P_MAX(P_MAX), .PW(PW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .thr_pstate_i(thr_pstate_i), .thr_idle_i(thr_idle_i),
  .core_idle_o(core_idle_o), .pkg_pstate_o(pkg_pstate_o),
  .c1e_en_o(c1e_en_o), .turbo_ok_o(turbo_ok_o)
);

// File: tb/sim_pwr_state_resolver.sv
`timescale 1ns/1ps
module sim_pwr_state_resolver;
  localparam int NC = 4;
  localparam int PM = 11;
  localparam int PW = 4;
  localparam int NT = 2 * NC;

  typedef struct packed {
    logic [NT*3-1:0]  idle;
    logic [NT*PW-1:0] pst;
    logic [NC*3-1:0]  core;
    logic [PW-1:0]    p;
    logic             c1e;
    logic             turbo;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{24'h0, 32'h5555_2555, 12'h000, 4'd2, 1'b0, 1'b0},
    '{{8{3'd2}}, 32'h3333_3333, {4{3'd2}}, 4'd11, 1'b1, 1'b0},
    '{{3'd1,3'd2,3'd2,3'd2,3'd2,3'd2,3'd2,3'd2}, 32'h0, {4{3'd1}}, 4'd11, 1'b0, 1'b0},
    '{{3'd3,3'd3,3'd6,3'd6,3'd6,3'd3,3'd6,3'd0}, 32'h0000_0007, {3'd3,3'd6,3'd3,3'd0}, 4'd7, 1'b0, 1'b1},
    '{{3'd3,3'd3,3'd6,3'd6,3'd1,3'd3,3'd0,3'd0}, 32'h0000_00CE, {3'd3,3'd6,3'd1,3'd0}, 4'd11, 1'b0, 1'b0},
    '{{3'd3,3'd6,3'd5,3'd5,3'd0,3'd7,3'd6,3'd4}, 32'h0000_4000, {3'd3,3'd1,3'd0,3'd1}, 4'd4, 1'b0, 1'b0},
    '{{8{3'd3}}, 32'h0, {4{3'd3}}, 4'd11, 1'b0, 1'b0},
    '{{3'd6,3'd6,3'd6,3'd6,3'd0,3'd0,3'd0,3'd0}, 32'h0000_BA89, {3'd6,3'd6,3'd0,3'd0}, 4'd8, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NT*PW-1:0] pst = '0;
  logic [NT*3-1:0]  idle = '0;
  logic [NC*3-1:0]  core_o;
  logic [PW-1:0]    p_o;
  logic             c1e_o, turbo_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pwr_state_resolver #(.NUM_CORES(NC), .P_MAX(PM), .PW(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .thr_pstate_i(pst), .thr_idle_i(idle),
    .core_idle_o(core_o), .pkg_pstate_o(p_o), .c1e_en_o(c1e_o), .turbo_ok_o(turbo_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] nrm(input logic [2:0] c);
    return (c == 3'd0 || c == 3'd1 || c == 3'd2 || c == 3'd3 || c == 3'd6) ? c : 3'd1;
  endfunction

  function automatic vec_t model(input logic [NT*3-1:0] id, input logic [NT*PW-1:0] ps);
    vec_t v;
    int deep = 0, run = 0;
    logic all2 = 1'b1;
    logic [2:0] m [NC];
    v.idle = id; v.pst = ps; v.p = PW'(PM);
    for (int c = 0; c < NC; c++) begin
      logic [2:0] a, b;
      a = nrm(id[(2*c)*3 +: 3]);
      b = nrm(id[(2*c+1)*3 +: 3]);
      m[c] = (a < b) ? a : b;
      if (m[c] != 3'd2) all2 = 1'b0;
      if (m[c] == 3'd3 || m[c] == 3'd6) deep++;
      if (m[c] == 3'd0) run++;
    end
    for (int t = 0; t < NT; t++) begin
      logic [PW-1:0] q;
      q = (ps[t*PW +: PW] > PW'(PM)) ? PW'(PM) : ps[t*PW +: PW];
      if (nrm(id[t*3 +: 3]) == 3'd0 && q < v.p) v.p = q;
    end
    for (int c = 0; c < NC; c++)
      v.core[c*3 +: 3] = (m[c] == 3'd2 && !all2) ? 3'd1 : m[c];
    v.c1e = all2;
    v.turbo = (deep == NC - 1) && (run == 1);
    return v;
  endfunction

  task automatic apply_check(input vec_t v, input string tag);
    vec_t prev;
    @(negedge clk);
    prev.core = core_o; prev.p = p_o; prev.c1e = c1e_o; prev.turbo = turbo_o;
    idle = v.idle; pst = v.pst;
    #2;
    chk(core_o == prev.core && p_o == prev.p, {"R8 no early change ", tag},
        {core_o, p_o}, {prev.core, prev.p});
    @(posedge clk); #5;
    chk(core_o == v.core, {"R2/R3/R9 core idle ", tag}, 32'(core_o), 32'(v.core));
    chk(p_o == v.p, {"R4/R5/R6 pkg pstate ", tag}, 32'(p_o), 32'(v.p));
    chk(c1e_o == v.c1e, {"R3 c1e ", tag}, 32'(c1e_o), 32'(v.c1e));
    chk(turbo_o == v.turbo, {"R7 turbo ", tag}, 32'(turbo_o), 32'(v.turbo));
  endtask

  function automatic logic [2:0] rnd_code(input int mode);
    int r;
    r = $urandom % 8;
    if (mode == 1) return (r < 6) ? 3'd2 : 3'(r % 3);
    if (mode == 2) return (r < 3) ? 3'd3 : (r < 6) ? 3'd6 : 3'd0;
    return 3'(r);
  endfunction

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #25;
    // R1 reset state
    chk(core_o == '0, "R1 core idle in reset", 32'(core_o), 0);
    chk(p_o == PW'(PM), "R1 pstate in reset", 32'(p_o), PM);
    chk(!c1e_o && !turbo_o, "R1 flags in reset", {c1e_o, turbo_o}, 0);
    @(negedge clk); rst_n = 1'b1;

    foreach (VEC[i]) apply_check(VEC[i], $sformatf("table %0d", i));

    for (int k = 0; k < 600; k++) begin
      logic [NT*3-1:0]  id;
      logic [NT*PW-1:0] ps;
      int mode;
      mode = k % 3;
      for (int t = 0; t < NT; t++) begin
        id[t*3 +: 3]  = rnd_code(mode);
        ps[t*PW +: PW] = PW'($urandom);
      end
      apply_check(model(id, ps), $sformatf("random %0d", k));
    end

    // R8 hold: same vector twice leaves outputs unchanged
    apply_check(VEC[3], "repeat a");
    apply_check(VEC[3], "repeat b");

    // R1 asynchronous reset mid-run
    @(negedge clk); #3 rst_n = 1'b0; #1;
    chk(core_o == '0 && p_o == PW'(PM) && !turbo_o, "R1 async reset",
        {core_o, p_o, turbo_o}, {12'h0, 4'(PM), 1'b0});
    @(negedge clk); rst_n = 1'b1;
    apply_check(VEC[1], "after reset");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule